// File: doc/BRIEF.md
# Grouped Distributed Priority Arbiter

This block decides which of up to 64 bus units wins the next transfer slot on a shared data bus. Each unit has a request flag and a programmable 7-bit priority. The two upper bits of the priority are a group number and the five lower bits are a level inside that group. The higher number always wins.

Arbitration runs in two stages, and both stages are modelled in this block. In the first stage, each requesting unit drives the bit for its group on a 4-line group field and checks that field. A unit that sees a group above its own withdraws. The units that remain drive the bit for their level on a 32-line level field. Both fields are built as explicit OR reductions of every unit's drivers, which is how wired-OR bus lines behave. In the second stage, a central picker finds the highest group and the highest remaining level. It then broadcasts the encoded winning priority, the winning unit's index and a one-hot granted flag.

A unit carrying priority 127 is meant for read-return traffic from the memory buffer, so it beats every other request. Two requesters may hold the same winning priority. When that happens, the lower unit index is granted and a configuration-error flag is raised with the grant. The data transfer itself is outside this block.

The controller steps through a fixed cycle of states:
- IDLE moves to SCAN on the next clock.
- SCAN captures the request flags and priorities. It moves to SETTLE if any request is present, and back to IDLE if there is none.
- SETTLE lasts one cycle. In it the two field stages resolve and the result is registered.
- GRANT presents the result for one cycle.
- XFER is the one-cycle transfer slot, after which the controller returns to IDLE.

Top module: `gdp_arbiter`

## Requirements
- R1: After reset, state_o is 0 (IDLE), grant_valid_o and tie_err_o are low, and granted_o is all zero.
- R2: The state code cycles IDLE(0) → SCAN(1) → SETTLE(2) → GRANT(3) → XFER(4) → IDLE(0). Each state lasts exactly one cycle.
- R3: If no req_i bit is set during SCAN, the next state is IDLE. No grant is asserted for that scan.
- R4: Priority bits [6:5] are the group and bits [4:0] are the level. A request in a higher group beats any request in a lower group, whatever the levels.
- R5: Among the requests of the surviving group, the highest level wins.
- R6: In GRANT, grant_valid_o is high, grant_prio_o holds the winning 7-bit priority, grant_unit_o holds the winner's index, and granted_o has exactly the winner's bit set. Outside GRANT, grant_valid_o and granted_o are zero.
- R7: When several requesters share the winning priority, the lowest index is granted and tie_err_o is high during GRANT. Otherwise tie_err_o is low.
- R8: The priority of a unit whose req_i bit is low has no effect on the outcome.
- R9: A requester at priority 127 wins over every requester below 127.
- R10: Requests and priorities are sampled at the end of the SCAN cycle. Changes made after that point do not affect the grant of that round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_UNITS | Per-unit request flags |
| prio_i | input | NUM_UNITS*7 | Per-unit priority; unit i occupies bits [7i+6:7i] |
| state_o | output | 3 | Controller state code |
| grant_valid_o | output | 1 | High in GRANT when a winner exists |
| grant_prio_o | output | 7 | Encoded winning priority |
| grant_unit_o | output | UNIT_IW | Index of the granted unit |
| granted_o | output | NUM_UNITS | One-hot granted flag per unit |
| tie_err_o | output | 1 | Duplicate winning priority detected |

## Verification
The assertions rely on one input condition. req_i and prio_i must be steady through the SCAN cycle, so that the empty-scan decision and the captured snapshot see the same requests. The survivor and level-field checks also assume that the snapshot cannot change during SETTLE. The stimulus meets this by changing inputs only just after the falling edge of an IDLE cycle, and it holds them until the round's result has been compared. The one deliberate exception is a round that scrambles the inputs during SETTLE, after capture, to show that the grant ignores late changes.

// File: rtl/gdp_pkg.sv
package gdp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SCAN   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_GRANT  = 3'd3,
        ST_XFER   = 3'd4
    } arb_state_e;
endpackage

// File: rtl/gdp_unit_req.sv
// Per-unit request logic: raises its group line, watches the group field,
// withdraws on a higher group, and otherwise raises its level line.
module gdp_unit_req #(
    parameter int GROUP_W = 2,
    parameter int LEVEL_W = 5,
    parameter int NG      = 1 << GROUP_W,
    parameter int NL      = 1 << LEVEL_W
) (
    input  logic                       req_i,
    input  logic [GROUP_W+LEVEL_W-1:0] prio_i,
    input  logic [NG-1:0]              group_bus_i,
    output logic [NG-1:0]              group_drv_o,
    output logic [NL-1:0]              level_drv_o,
    output logic                       stay_o
);
    logic [GROUP_W-1:0] grp;
    logic [LEVEL_W-1:0] lvl;
    logic               higher_seen;

    assign grp = prio_i[GROUP_W+LEVEL_W-1 -: GROUP_W];
    assign lvl = prio_i[LEVEL_W-1:0];

    always_comb begin
        higher_seen = 1'b0;
        for (int k = 0; k < NG; k++) begin
            if (group_bus_i[k] && (k > int'(grp))) higher_seen = 1'b1;
        end
    end

    assign group_drv_o = req_i ? (NG'(1) << grp) : '0;
    assign stay_o      = req_i & ~higher_seen;
    assign level_drv_o = stay_o ? (NL'(1) << lvl) : '0;
endmodule

// File: rtl/gdp_central.sv
// Central picker: highest group line, highest level line, lowest index on tie.
module gdp_central #(
    parameter int NUM_UNITS = 64,
    parameter int GROUP_W   = 2,
    parameter int LEVEL_W   = 5,
    parameter int UNIT_IW   = $clog2(NUM_UNITS),
    parameter int NG        = 1 << GROUP_W,
    parameter int NL        = 1 << LEVEL_W
) (
    input  logic [NG-1:0]              group_bus_i,
    input  logic [NL-1:0]              level_bus_i,
    input  logic [NUM_UNITS-1:0]       stay_i,
    input  logic [LEVEL_W-1:0]         lvl_i [NUM_UNITS],
    output logic                       any_o,
    output logic [GROUP_W+LEVEL_W-1:0] win_prio_o,
    output logic [UNIT_IW-1:0]         win_unit_o,
    output logic                       tie_o
);
    localparam int CW = $clog2(NUM_UNITS + 1);

    logic [GROUP_W-1:0] top_grp;
    logic [LEVEL_W-1:0] top_lvl;
    logic [CW-1:0]      hits;

    always_comb begin
        top_grp = '0;
        for (int k = 0; k < NG; k++) begin
            if (group_bus_i[k]) top_grp = GROUP_W'(k);
        end
        top_lvl = '0;
        for (int k = 0; k < NL; k++) begin
            if (level_bus_i[k]) top_lvl = LEVEL_W'(k);
        end
    end

    always_comb begin
        win_unit_o = '0;
        hits       = '0;
        for (int i = NUM_UNITS - 1; i >= 0; i--) begin
            if (stay_i[i] && (lvl_i[i] == top_lvl)) begin
                win_unit_o = UNIT_IW'(i);
                hits       = hits + CW'(1);
            end
        end
    end

    assign any_o      = |level_bus_i;
    assign win_prio_o = {top_grp, top_lvl};
    assign tie_o      = (hits > CW'(1));
endmodule

// File: rtl/gdp_arbiter.sv
module gdp_arbiter
    import gdp_pkg::*;
#(
    parameter int NUM_UNITS = 64,
    parameter int GROUP_W   = 2,
    parameter int LEVEL_W   = 5,
    parameter int PRIO_W    = GROUP_W + LEVEL_W,
    parameter int UNIT_IW   = $clog2(NUM_UNITS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_UNITS-1:0]        req_i,
    input  logic [NUM_UNITS*PRIO_W-1:0] prio_i,
    output logic [2:0]                  state_o,
    output logic                        grant_valid_o,
    output logic [PRIO_W-1:0]           grant_prio_o,
    output logic [UNIT_IW-1:0]          grant_unit_o,
    output logic [NUM_UNITS-1:0]        granted_o,
    output logic                        tie_err_o
);
    localparam int NG = 1 << GROUP_W;
    localparam int NL = 1 << LEVEL_W;

    arb_state_e state, state_nx;

    logic [NUM_UNITS-1:0]        req_q;
    logic [NUM_UNITS*PRIO_W-1:0] prio_q;

    logic [NG-1:0]        group_drv [NUM_UNITS];
    logic [NL-1:0]        level_drv [NUM_UNITS];
    logic [LEVEL_W-1:0]   lvl       [NUM_UNITS];
    logic [NUM_UNITS-1:0] stay;
    logic [NG-1:0]        group_bus;
    logic [NL-1:0]        level_bus;

    logic                 c_any, c_tie;
    logic [PRIO_W-1:0]    c_prio;
    logic [UNIT_IW-1:0]   c_unit;

    logic                 res_valid, res_tie;
    logic [PRIO_W-1:0]    res_prio;
    logic [UNIT_IW-1:0]   res_unit;

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = ST_SCAN;
            ST_SCAN:   state_nx = (|req_i) ? ST_SETTLE : ST_IDLE;
            ST_SETTLE: state_nx = ST_GRANT;
            ST_GRANT:  state_nx = ST_XFER;
            ST_XFER:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register, snapshot and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            req_q     <= '0;
            prio_q    <= '0;
            res_valid <= 1'b0;
            res_tie   <= 1'b0;
            res_prio  <= '0;
            res_unit  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_SCAN) begin
                req_q  <= req_i;
                prio_q <= prio_i;
            end
            if (state == ST_SETTLE) begin
                res_valid <= c_any;
                res_tie   <= c_tie;
                res_prio  <= c_prio;
                res_unit  <= c_unit;
            end
        end
    end

    // per-unit request logic
    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        gdp_unit_req #(.GROUP_W(GROUP_W), .LEVEL_W(LEVEL_W)) u_req (
            .req_i       (req_q[i]),
            .prio_i      (prio_q[i*PRIO_W +: PRIO_W]),
            .group_bus_i (group_bus),
            .group_drv_o (group_drv[i]),
            .level_drv_o (level_drv[i]),
            .stay_o      (stay[i])
        );
        assign lvl[i] = prio_q[i*PRIO_W +: LEVEL_W];
    end

    // wired-OR bus fields
    always_comb begin
        group_bus = '0;
        level_bus = '0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            group_bus = group_bus | group_drv[i];
            level_bus = level_bus | level_drv[i];
        end
    end

    gdp_central #(
        .NUM_UNITS(NUM_UNITS), .GROUP_W(GROUP_W),
        .LEVEL_W(LEVEL_W), .UNIT_IW(UNIT_IW)
    ) u_central (
        .group_bus_i (group_bus),
        .level_bus_i (level_bus),
        .stay_i      (stay),
        .lvl_i       (lvl),
        .any_o       (c_any),
        .win_prio_o  (c_prio),
        .win_unit_o  (c_unit),
        .tie_o       (c_tie)
    );

    // outputs
    always_comb begin
        state_o       = state;
        grant_valid_o = 1'b0;
        grant_prio_o  = '0;
        grant_unit_o  = '0;
        granted_o     = '0;
        tie_err_o     = 1'b0;
        unique case (state)
            ST_GRANT: begin
                grant_valid_o = res_valid;
                grant_prio_o  = res_prio;
                grant_unit_o  = res_unit;
                granted_o     = res_valid ? (NUM_UNITS'(1) << res_unit) : '0;
                tie_err_o     = res_valid & res_tie;
            end
            default: ;
        endcase
    end

    // assertions
    assert_settle_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SETTLE |=> state == ST_GRANT);
    assert_grant_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_GRANT |=> state == ST_XFER);
    assert_xfer_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_XFER |=> state == ST_IDLE);
    assert_idle_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |=> state == ST_SCAN);
    assert_empty_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && !(|req_i)) |=> (state == ST_IDLE && !grant_valid_o));
    assert_level_after_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && |group_bus) |-> |level_bus);
    assert_granted_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> $onehot(granted_o));
    assert_granted_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid_o |-> (granted_o == '0 && !tie_err_o));

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_chk
        assert_survivor_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_SETTLE && stay[i]) |->
                (prio_q[i*PRIO_W+LEVEL_W +: GROUP_W] == c_prio[PRIO_W-1 -: GROUP_W]));
    end
endmodule

// File: tb/gdp_arbiter_tb.sv
module gdp_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 64;
    localparam int PW = 7;

    typedef struct {
        bit       valid;
        bit [6:0] prio;
        bit [5:0] unit;
        bit       tie;
        string    tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_i = '0;
    logic [N*PW-1:0] prio_i = '0;
    logic [2:0]    state_o;
    logic          grant_valid_o;
    logic [6:0]    grant_prio_o;
    logic [5:0]    grant_unit_o;
    logic [N-1:0]  granted_o;
    logic          tie_err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    exp_t q[$];

    logic [N-1:0] req_v;
    logic [6:0]   pr_v [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    gdp_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_i(prio_i),
        .state_o(state_o), .grant_valid_o(grant_valid_o),
        .grant_prio_o(grant_prio_o), .grant_unit_o(grant_unit_o),
        .granted_o(granted_o), .tie_err_o(tie_err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_v();
        req_v = '0;
        for (int i = 0; i < N; i++) pr_v[i] = 7'd0;
    endtask

    // driver: waits for IDLE, drives, pushes the model's expectation
    task automatic apply(input string tag, input bit scramble);
        exp_t e;
        int best;
        int cnt;
        do @(negedge clk); while (state_o != 3'd0);
        #1;
        best = -1;
        cnt  = 0;
        for (int i = 0; i < N; i++) begin
            if (req_v[i]) begin
                if (best < 0 || pr_v[i] > pr_v[best]) begin
                    best = i;
                    cnt  = 1;
                end else if (pr_v[i] == pr_v[best]) begin
                    cnt++;
                end
            end
        end
        e.valid = (best >= 0);
        e.prio  = (best >= 0) ? pr_v[best] : 7'd0;
        e.unit  = (best >= 0) ? 6'(best) : 6'd0;
        e.tie   = (cnt > 1);
        e.tag   = tag;
        req_i = req_v;
        for (int i = 0; i < N; i++) prio_i[i*PW +: PW] = pr_v[i];
        q.push_back(e);
        if (scramble) begin
            do @(negedge clk); while (state_o != 3'd2);
            #1;
            req_i  = '1;
            prio_i = '1;
        end
        while (q.size() != 0) @(negedge clk);
        #1;
        req_i = '0;
    endtask

    // monitor
    initial begin
        logic [2:0] prev;
        exp_t e;
        prev = 3'd0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (prev == 3'd3)
                check(state_o == 3'd4, "R2", "state after GRANT", state_o, 4);
            if (prev == 3'd4)
                check(state_o == 3'd0, "R2", "state after XFER", state_o, 0);
            if (prev == 3'd2)
                check(state_o == 3'd3, "R2", "state after SETTLE", state_o, 3);
            if (state_o == 3'd3) begin
                if (q.size() == 0) begin
                    check(1'b0, "R6", "unexpected GRANT", 1, 0);
                end else begin
                    e = q.pop_front();
                    check(grant_valid_o == e.valid, e.tag, "grant_valid", grant_valid_o, e.valid);
                    check(grant_prio_o == e.prio, e.tag, "grant_prio", grant_prio_o, e.prio);
                    check(grant_unit_o == e.unit, e.tag, "grant_unit", grant_unit_o, e.unit);
                    check(granted_o == (64'd1 << e.unit), "R6", "granted one-hot",
                          granted_o, 64'd1 << e.unit);
                    check(tie_err_o == e.tie, "R7", "tie flag", tie_err_o, e.tie);
                end
            end else if (prev == 3'd1 && state_o == 3'd0 && q.size() != 0) begin
                e = q.pop_front();
                check(!e.valid && !grant_valid_o, "R3", "empty scan", grant_valid_o, 0);
            end else if (state_o != 3'd3) begin
                check(!grant_valid_o && granted_o == '0, "R6", "quiet outside GRANT",
                      granted_o, 0);
            end
            prev = state_o;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(state_o == 3'd0 && !grant_valid_o && !tie_err_o && granted_o == '0,
              "R1", "reset state", state_o, 0);
        rst_n = 1'b1;

        clear_v(); req_v[5] = 1; pr_v[5] = 7'h23;
        apply("R6", 0);

        clear_v(); req_v[10] = 1; pr_v[10] = 7'd63; req_v[40] = 1; pr_v[40] = 7'd64;
        apply("R4", 0);

        clear_v(); req_v[3] = 1; pr_v[3] = 7'd70; req_v[60] = 1; pr_v[60] = 7'd90;
        req_v[30] = 1; pr_v[30] = 7'd20;
        apply("R5", 0);

        clear_v(); req_v[7] = 1; pr_v[7] = 7'd50; req_v[20] = 1; pr_v[20] = 7'd50;
        req_v[1] = 1; pr_v[1] = 7'd49;
        apply("R7", 0);

        clear_v(); req_v[2] = 1; pr_v[2] = 7'd10; pr_v[9] = 7'd127; pr_v[0] = 7'd100;
        apply("R8", 0);

        clear_v();
        for (int i = 0; i < N - 1; i++) begin req_v[i] = 1; pr_v[i] = 7'd126; end
        req_v[63] = 1; pr_v[63] = 7'd127;
        apply("R9", 0);

        clear_v();
        apply("R3", 0);

        clear_v(); req_v[1] = 1; pr_v[1] = 7'd5;
        apply("R10", 1);

        clear_v();
        for (int i = 0; i < N; i++) begin req_v[i] = 1; pr_v[i] = 7'(2 * i); end
        apply("R4", 0);

        for (int r = 0; r < 12; r++) begin
            clear_v();
            for (int i = 0; i < N; i++) begin
                req_v[i] = ($urandom % 3) == 0;
                pr_v[i]  = 7'($urandom % 40 + (r % 4) * 29);
            end
            apply("R5", 0);
        end

        repeat (6) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule